// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Controller

This block gives a group of harts their machine timer and machine software interrupts. One free-running 64-bit time count is shared by all harts. It advances by one on each clock where `tick_en` is high. Each hart owns a 64-bit compare value and a one-bit software-interrupt flag. The timer interrupt of a hart is a level. It stays high while the hart's compare value is at or below the time count, and it is checked again on every clock. A counter advance on its own can therefore raise it, and a compare write can raise or drop it at once.

Software reaches the registers over a plain 32-bit bus with byte addresses, a write strobe, a read strobe, write data and registered read data. The 64-bit values are reached as two 32-bit words. Writing one word leaves the other word as it was. The three regions sit at configurable bases inside one aperture: software flags, compare words and time words. Output bit i belongs to the i-th hart served, counted from the first hart of the group. An access that is misaligned, names a hart the block does not serve, or lands where nothing is mapped changes nothing. The block reports it through a one-cycle error flag.

Top module: `core_timer_intc`

## Requirements
- R1: After reset the time count and every compare value are zero and every software flag is zero, so `soft_irq` is all zeros and `timer_irq` is all ones.
- R2: A write at byte address CMP_BASE + 8*i replaces bits 31:0 of hart i's compare value with `bus_wdata` and keeps bits 63:32.
- R3: A write at CMP_BASE + 8*i + 4 replaces bits 63:32 of hart i's compare value and keeps bits 31:0.
- R4: `timer_irq[i]` is 1 exactly when hart i's compare value is less than or equal to the time count. It follows a compare write or a tick in the cycle right after that clock edge, so a compare set in the past asserts it at once.
- R5: The time count rises by one on each clock edge where `tick_en` is 1 and holds otherwise. Its low word is read at TIME_BASE and its high word at TIME_BASE + 4. A read returns the value from before that edge. A write to either time word changes nothing and is flagged as an error.
- R6: A write at SWI_BASE + 4*i sets hart i's software flag to `bus_wdata[0]` and drives `soft_irq[i]` from the next cycle. A read at that address returns the flag in bit 0 and zeros in bits 31:1.
- R7: A read (`bus_re`=1, `bus_we`=0) presents its word on `bus_rdata` one cycle later. A read of a compare word returns the stored half. In every cycle that does not follow a valid read, `bus_rdata` is zero.
- R8: An access is faulty when its address is at or above APERTURE, or lies outside all three regions, or has bits 1:0 not zero, or names a hart index of NUM_HARTS or more, or is a write to a time word. A faulty access changes no state. It sets `bus_err` for exactly the one following cycle with `bus_rdata` zero.
- R9: The timer and software outputs are separate per-hart vectors. An access to hart i changes only index i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances the time count by one on this edge |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_err | output | 1 | Pulses one cycle after a faulty access |
| timer_irq | output | NUM_HARTS | Machine timer interrupt per hart |
| soft_irq | output | NUM_HARTS | Machine software interrupt per hart |

## Verification
A wrong compare or time state shows up on `timer_irq` in the cycle after the write or tick that caused it, because the comparison is a live level. Word-select or keep-the-other-half errors show in the next read of the neighbouring word. A wrong software flag shows on `soft_irq` one cycle after the write. A decode fault that slips through either changes a register, which a later read or interrupt level exposes. If it goes the other way, it shows as a missing or extra one-cycle `bus_err` pulse right after the access.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_SWI  = 2'd1,
    RGN_CMP  = 2'd2,
    RGN_TIME = 2'd3
  } rgn_e;

  // Timer condition: compare value at or below the live count.
  function automatic logic cmp_due(input logic [63:0] cmpv, input logic [63:0] now);
    return cmpv <= now;
  endfunction

  // Replace one 32-bit half of a 64-bit value, keep the other.
  function automatic logic [63:0] merge_half(input logic [63:0] old,
                                             input logic        hi,
                                             input logic [31:0] w);
    return hi ? {w, old[31:0]} : {old[63:32], w};
  endfunction

  function automatic logic [31:0] pick_half(input logic [63:0] v, input logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

endpackage

// File: rtl/ctl_addr_decode.sv
module ctl_addr_decode
  import ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned SWI_BASE  = 32'h0000_0000,
  parameter int unsigned CMP_BASE  = 32'h0000_4000,
  parameter int unsigned TIME_BASE = 32'h0000_BFF8,
  parameter int unsigned APERTURE  = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  output rgn_e              rgn,
  output logic [IDX_W-1:0]  hart,
  output logic              hi,
  output logic              ok,
  output logic              bad
);

  localparam logic [31:0] TIME_END = 32'(TIME_BASE) + 32'd8;

  logic [31:0] a;
  logic [31:0] idx32;
  logic        misalign;
  logic        idx_over;
  logic        fault;
  logic        access;

  assign a = 32'(addr);

  always_comb begin
    rgn   = RGN_NONE;
    idx32 = '0;
    if (a < 32'(APERTURE)) begin
      if (a >= 32'(SWI_BASE) && a < 32'(CMP_BASE)) begin
        rgn   = RGN_SWI;
        idx32 = (a - 32'(SWI_BASE)) >> 2;
      end else if (a >= 32'(CMP_BASE) && a < 32'(TIME_BASE)) begin
        rgn   = RGN_CMP;
        idx32 = (a - 32'(CMP_BASE)) >> 3;
      end else if (a >= 32'(TIME_BASE) && a < TIME_END) begin
        rgn   = RGN_TIME;
      end
    end
  end

  assign misalign = (a[1:0] != 2'b00);
  assign idx_over = (idx32 >= 32'(NUM_HARTS));
  assign hi       = a[2];
  assign hart     = idx32[IDX_W-1:0];

  assign fault  = (rgn == RGN_NONE) || misalign ||
                  (((rgn == RGN_SWI) || (rgn == RGN_CMP)) && idx_over) ||
                  ((rgn == RGN_TIME) && we);
  assign access = we || re;
  assign ok     = access && !fault;
  assign bad    = access && fault;

endmodule

// File: rtl/ctl_time_base.sv
module ctl_time_base #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  output logic [W-1:0] now
);

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else if (tick_en) now <= now + W'(1);
  end

  // R5
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(now));

  // R5
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> !$stable(now));

endmodule

// File: rtl/ctl_hart_slot.sv
module ctl_hart_slot
  import ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_wr,
  input  logic        cmp_hi,
  input  logic        swi_wr,
  input  logic [31:0] wdata,
  input  logic [63:0] now,
  output logic [63:0] cmp_q,
  output logic        swi_q,
  output logic        timer_irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) cmp_q <= '0;
    else if (cmp_wr) cmp_q <= merge_half(cmp_q, cmp_hi, wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) swi_q <= 1'b0;
    else if (swi_wr) swi_q <= wdata[0];
  end

  assign timer_irq = cmp_due(cmp_q, now);

  // R2
  cmp_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !cmp_hi) |=> (cmp_q[63:32] == $past(cmp_q[63:32])));

  // R3
  cmp_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && cmp_hi) |=> (cmp_q[31:0] == $past(cmp_q[31:0])));

  // R4
  timer_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(timer_irq) |-> ($past(cmp_wr) || !$stable(now)));

  // R6
  swi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(swi_q) |-> $past(swi_wr));

endmodule

// File: rtl/core_timer_intc.sv
module core_timer_intc
  import ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned SWI_BASE  = 32'h0000_0000,
  parameter int unsigned CMP_BASE  = 32'h0000_4000,
  parameter int unsigned TIME_BASE = 32'h0000_BFF8,
  parameter int unsigned APERTURE  = 32'h0001_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic [NUM_HARTS-1:0] timer_irq,
  output logic [NUM_HARTS-1:0] soft_irq
);

  localparam int unsigned IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  rgn_e             dec_rgn;
  logic [IDX_W-1:0] dec_hart;
  logic             dec_hi;
  logic             dec_ok;
  logic             dec_bad;

  logic [63:0]          now;
  logic [63:0]          cmp_all [NUM_HARTS];
  logic [NUM_HARTS-1:0] cmp_wr_vec;
  logic [NUM_HARTS-1:0] swi_wr_vec;
  logic                 any_cmp_wr;
  logic                 any_swi_wr;
  logic [31:0]          rd_word;
  logic                 rd_take;

  ctl_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS), .IDX_W(IDX_W),
    .SWI_BASE(SWI_BASE), .CMP_BASE(CMP_BASE),
    .TIME_BASE(TIME_BASE), .APERTURE(APERTURE)
  ) u_dec (
    .addr(bus_addr), .we(bus_we), .re(bus_re),
    .rgn(dec_rgn), .hart(dec_hart), .hi(dec_hi),
    .ok(dec_ok), .bad(dec_bad)
  );

  ctl_time_base #(.W(64)) u_time (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .now(now)
  );

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
    assign cmp_wr_vec[g] = bus_we && dec_ok && (dec_rgn == RGN_CMP) &&
                           (dec_hart == IDX_W'(g));
    assign swi_wr_vec[g] = bus_we && dec_ok && (dec_rgn == RGN_SWI) &&
                           (dec_hart == IDX_W'(g));

    ctl_hart_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .cmp_wr(cmp_wr_vec[g]), .cmp_hi(dec_hi),
      .swi_wr(swi_wr_vec[g]), .wdata(bus_wdata),
      .now(now), .cmp_q(cmp_all[g]),
      .swi_q(soft_irq[g]), .timer_irq(timer_irq[g])
    );
  end

  assign any_cmp_wr = |cmp_wr_vec;
  assign any_swi_wr = |swi_wr_vec;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (dec_hart == IDX_W'(i)) begin
        if (dec_rgn == RGN_SWI) rd_word = {31'b0, soft_irq[i]};
        if (dec_rgn == RGN_CMP) rd_word = pick_half(cmp_all[i], dec_hi);
      end
    end
    if (dec_rgn == RGN_TIME) rd_word = pick_half(now, dec_hi);
  end

  assign rd_take = bus_re && !bus_we && dec_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_take ? rd_word : 32'd0;
      bus_err   <= dec_bad;
    end
  end

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_we || bus_re));

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == 32'd0));

  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_re) |-> (bus_rdata == 32'd0));

  // R9
  one_cmp_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_wr_vec) && $onehot0(swi_wr_vec));

  // R9
  no_mixed_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_cmp_wr && any_swi_wr));

endmodule

// File: tb/core_timer_intc_tb.sv
module core_timer_intc_tb;

  localparam int NH = 4;
  localparam int SWI = 'h0000;
  localparam int CMP = 'h4000;
  localparam int TIM = 'hBFF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [16:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [NH-1:0] timer_irq;
  logic [NH-1:0] soft_irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  core_timer_intc u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .timer_irq(timer_irq), .soft_irq(soft_irq)
  );

  // Behavioural reference state
  longint unsigned m_time;
  longint unsigned m_cmp [NH];
  bit              m_sw  [NH];
  logic [31:0]     m_rd;
  bit              m_err;

  // Classify an access: kind 0 none, 1 soft flag, 2 compare, 3 time
  task automatic classify(input int unsigned a, input bit we,
                          output int kind, output int h, output int half,
                          output bit fault);
    kind = 0; h = 0; half = 0; fault = 1;
    if (a >= 'h10000) return;
    if (a % 4 != 0) begin
      fault = 1;
      return;
    end
    if (a < CMP) begin
      kind = 1; h = int'(a) / 4;
      fault = (h >= NH);
    end else if (a < TIM) begin
      kind = 2; h = (int'(a) - CMP) / 8; half = (int'(a) / 4) % 2;
      fault = (h >= NH);
    end else if (a < TIM + 8) begin
      kind = 3; half = (int'(a) - TIM) / 4;
      fault = we;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_time = 0;
      for (int i = 0; i < NH; i++) begin
        m_cmp[i] = 0;
        m_sw[i]  = 0;
      end
      m_rd = 0; m_err = 0;
    end else begin
      int  k, h, hf;
      bit  f;
      m_rd = 0; m_err = 0;
      if (bus_we || bus_re) begin
        classify(32'(bus_addr), bus_we, k, h, hf, f);
        m_err = f;
        if (!f) begin
          if (bus_we) begin
            if (k == 1) m_sw[h] = bus_wdata[0];
            if (k == 2) begin
              if (hf == 1) m_cmp[h] = {bus_wdata, m_cmp[h][31:0]};
              else         m_cmp[h] = {m_cmp[h][63:32], bus_wdata};
            end
          end else begin
            if (k == 1) m_rd = {31'b0, m_sw[h]};
            if (k == 2) m_rd = (hf == 1) ? m_cmp[h][63:32] : m_cmp[h][31:0];
            if (k == 3) m_rd = (hf == 1) ? m_time[63:32] : m_time[31:0];
          end
        end
      end
      if (tick_en) m_time = m_time + 1;
    end
  end

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NH-1:0] et, es;
      for (int i = 0; i < NH; i++) begin
        et[i] = (m_cmp[i] <= m_time);
        es[i] = m_sw[i];
      end
      checks += 4;
      if (timer_irq !== et) begin
        fails++;
        $display("FAIL R4 timer_irq actual %b expected %b", timer_irq, et);
      end
      if (soft_irq !== es) begin
        fails++;
        $display("FAIL R6 soft_irq actual %b expected %b", soft_irq, es);
      end
      if (bus_rdata !== m_rd) begin
        fails++;
        $display("FAIL R7 bus_rdata actual %h expected %h", bus_rdata, m_rd);
      end
      if (bus_err !== m_err) begin
        fails++;
        $display("FAIL R8 bus_err actual %b expected %b", bus_err, m_err);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input int unsigned a, input bit we, input bit re,
                        input logic [31:0] d, input bit tk);
    @(negedge clk);
    bus_addr = 17'(a); bus_we = we; bus_re = re; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_we = 0; bus_re = 0; tick_en = 0;
  endtask

  task automatic wr(input int unsigned a, input logic [31:0] d);
    bus_op(a, 1, 0, d, 0);
  endtask

  task automatic rd_chk(input int unsigned a, input logic [31:0] exp, input string tag);
    bus_op(a, 0, 1, 0, 0);
    check(tag, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 timer_irq", 32'(timer_irq), 32'hF);
    check("R1 soft_irq", 32'(soft_irq), 32'h0);
    rd_chk(TIM, 0, "R1 time low");
    rd_chk(CMP + 8, 0, "R1 cmp1 low");

    // R2 low half write
    wr(CMP, 10);
    check("R4 timer0 future", 32'(timer_irq[0]), 0);
    rd_chk(CMP, 10, "R2 cmp0 low");
    wr(CMP + 4, 0);
    rd_chk(CMP, 10, "R3 cmp0 low kept");
    // R3 high half write, R9 isolation
    wr(CMP + 12, 1);
    rd_chk(CMP + 12, 1, "R3 cmp1 high");
    rd_chk(CMP + 8, 0, "R3 cmp1 low kept");
    check("R9 timer vector", 32'(timer_irq), 32'b1100);
    wr(CMP + 8, 32'h55);
    rd_chk(CMP + 12, 1, "R2 cmp1 high kept");

    // R4 counter advance raises the timer
    ticks(9);
    check("R4 before reach", 32'(timer_irq[0]), 0);
    ticks(1);
    check("R4 reached", 32'(timer_irq[0]), 1);
    rd_chk(TIM, 10, "R5 time low");
    rd_chk(TIM + 4, 0, "R5 time high");

    // R4 past compare asserts at once
    wr(CMP + 16, 100);
    check("R4 hart2 future", 32'(timer_irq[2]), 0);
    wr(CMP + 16, 3);
    check("R4 hart2 past", 32'(timer_irq[2]), 1);

    // R6 software flags
    wr(SWI + 4, 32'hFFFF_FFFF);
    check("R6 soft set", 32'(soft_irq), 32'b0010);
    rd_chk(SWI + 4, 1, "R6 soft readback");
    wr(SWI + 4, 2);
    check("R6 soft clear", 32'(soft_irq), 0);

    // R8 faulty accesses
    wr(SWI + 6, 1);
    check("R8 misaligned err", 32'(bus_err), 1);
    check("R8 misaligned no effect", 32'(soft_irq), 0);
    @(negedge clk);
    check("R8 err one cycle", 32'(bus_err), 0);
    wr(SWI + 16, 1);
    check("R8 hart range err", 32'(bus_err), 1);
    wr(CMP + 32, 0);
    check("R8 cmp hart range err", 32'(bus_err), 1);
    wr(CMP + 2, 0);
    check("R8 cmp misaligned err", 32'(bus_err), 1);
    rd_chk(CMP, 10, "R8 cmp unchanged");
    wr(TIM, 32'h1234);
    check("R5 time write err", 32'(bus_err), 1);
    rd_chk(TIM, 10, "R5 time unchanged");
    rd_chk('hC000, 0, "R8 unmapped data");
    check("R8 unmapped err", 32'(bus_err), 1);
    rd_chk('h10004, 0, "R8 outside aperture");
    rd_chk('h8000, 0, "R8 far hart index");

    // Mixed traffic with ticks, checked by the reference every cycle
    for (int n = 0; n < 600; n++) begin
      int unsigned a;
      int sel = $urandom_range(0, 9);
      logic [31:0] d = 32'($urandom_range(0, 60));
      case (sel)
        0, 1: a = SWI + 4 * $urandom_range(0, NH);
        2, 3, 4: a = CMP + 8 * $urandom_range(0, NH);
        5: a = CMP + 8 * $urandom_range(0, NH - 1) + 4;
        6: a = TIM + 4 * $urandom_range(0, 1);
        7: a = $urandom_range(0, 'h11000);
        default: a = CMP + 8 * $urandom_range(0, NH - 1) + $urandom_range(0, 3);
      endcase
      if (sel == 5) d = ($urandom_range(0, 7) == 0) ? 32'd1 : 32'd0;
      bus_op(a, $urandom_range(0, 1) == 1, 1'b1, d, $urandom_range(0, 1) == 1);
    end

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule